// File: doc/BRIEF.md
# Major-Axis Line Drawing Engine

This block traces a straight line of pixels from a programmed origin. The host does not hand over two endpoints. It supplies the length of the long side, the length of the short side, a flag that says which screen axis is the long one, and one reverse-direction flag per axis. Writing the command strobe starts the line. For each pixel, the engine moves the long-axis coordinate by one. It adds the short length to an error accumulator, and it moves the short-axis coordinate whenever that accumulator reaches the long length.

Each pixel leaves the block as a write request carrying X, Y and colour over a valid/ready handshake, so a memory port downstream can stall the engine at any time. Busy stays high for the whole line. A single-cycle done pulse marks the end. The colour is latched at launch. In narrow colour mode only its low nibble is kept.

Top module: `majline_engine`

## Requirements
- R1: While reset is asserted and after it is released with no command, busy, pix_valid and done are all 0.
- R2: A cmd_go pulse sampled while idle latches all command inputs. On the following cycle busy and pix_valid are 1 and the request carries the origin (org_x, org_y).
- R3: A line with long length L produces exactly L+1 accepted pixel requests, including the origin and the far endpoint. L = 0 yields only the origin.
- R4: Each accepted request except the last moves the long-axis coordinate by exactly one. major_y = 0 selects X as the long axis and major_y = 1 selects Y.
- R5: The error accumulator starts at floor(L/2). For the k-th pixel (k = 0 for the origin) the short-axis offset from the origin is floor((floor(L/2) + k*S)/L), where S is the short length and S <= L.
- R6: x_rev = 1 makes X move downward and y_rev = 1 makes Y move downward. Coordinates wrap modulo 2^XW and 2^YW.
- R7: With colour_wide = 1 the request colour equals the latched 8-bit colour. With colour_wide = 0 bits 7..4 read 0 and bits 3..0 equal the colour's low bits.
- R8: While pix_valid is 1 and pix_ready is 0, the request (valid, X, Y, colour) holds unchanged.
- R9: done is high for exactly one cycle. That cycle directly follows the acceptance of the final pixel, and busy is already 0 in it.
- R10: cmd_go and changes to the command inputs while busy have no effect on the line being drawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command strobe; starts a line when idle |
| org_x | input | XW (9) | Start X coordinate |
| org_y | input | YW (10) | Start Y coordinate |
| len_long | input | LEN_W (10) | Long-side length L |
| len_short | input | LEN_W (10) | Short-side length S |
| colour | input | COL_W (8) | Pixel colour |
| colour_wide | input | 1 | 1 keeps all colour bits, 0 keeps the low nibble |
| major_y | input | 1 | 0: X is the long axis, 1: Y is the long axis |
| x_rev | input | 1 | 1: X steps are negative |
| y_rev | input | 1 | 1: Y steps are negative |
| pix_valid | output | 1 | Pixel write request valid |
| pix_ready | input | 1 | Downstream accepts the request |
| pix_x | output | XW (9) | Request X |
| pix_y | output | YW (10) | Request Y |
| pix_col | output | COL_W (8) | Request colour |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench sweeps every short length against every long length up to twelve, for all eight axis and direction combinations, under an irregular ready pattern. Three kinds of error show up in that sweep. An accumulator seeded at zero instead of half, or a compare using ">" instead of ">=", moves the short axis one pixel early or late. An off-by-one terminal count drops the far endpoint or adds a pixel after it, which is most visible at L = 0. A swapped direction flag walks the wrong way. Origins at 0 and at the top of the coordinate range catch a design that saturates instead of wrapping. A command fired mid-line catches an engine that re-latches while busy. The S = L diagonal and a maximum-length line exercise the widest accumulator sums.

// File: rtl/majline_pkg.sv
package majline_pkg;
   typedef enum logic [0:0] {
      LS_IDLE = 1'b0,
      LS_RUN  = 1'b1
   } ln_state_e;
endpackage

// File: rtl/majline_ctrl.sv
module majline_ctrl
   import majline_pkg::*;
#(
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             accept,
   input  logic [LEN_W-1:0] len_long,
   output logic             busy,
   output logic             done,
   output logic             last
);
   ln_state_e        st_q;
   logic [LEN_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= LS_IDLE;
         remain_q <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            LS_IDLE: begin
               if (launch) begin
                  st_q     <= LS_RUN;
                  remain_q <= len_long;
               end
            end
            LS_RUN: begin
               if (accept) begin
                  if (remain_q == '0) begin
                     st_q <= LS_IDLE;
                     done <= 1'b1;
                  end else begin
                     remain_q <= remain_q - 1'b1;
                  end
               end
            end
            default: st_q <= LS_IDLE;
         endcase
      end
   end

   assign busy = (st_q == LS_RUN);
   assign last = (remain_q == '0);
endmodule

// File: rtl/majline_err.sv
module majline_err #(
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             advance,
   input  logic [LEN_W-1:0] len_long,
   input  logic [LEN_W-1:0] len_short,
   output logic             minor_step
);
   localparam int ACC_W = LEN_W + 1;

   logic [LEN_W-1:0] lng_q, sht_q;
   logic [ACC_W-1:0] acc_q, sum;

   assign sum        = acc_q + {1'b0, sht_q};
   assign minor_step = (sum >= {1'b0, lng_q});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lng_q <= '0;
         sht_q <= '0;
         acc_q <= '0;
      end else if (launch) begin
         lng_q <= len_long;
         sht_q <= len_short;
         acc_q <= {2'b00, len_long[LEN_W-1:1]};
      end else if (advance) begin
         acc_q <= minor_step ? (sum - {1'b0, lng_q}) : sum;
      end
   end
endmodule

// File: rtl/majline_coord.sv
module majline_coord #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         launch,
   input  logic [W-1:0] init,
   input  logic         step,
   input  logic         neg,
   output logic [W-1:0] pos
);
   always_ff @(posedge clk) begin
      if (!rst_n)      pos <= '0;
      else if (launch) pos <= init;
      else if (step)   pos <= neg ? (pos - 1'b1) : (pos + 1'b1);
   end
endmodule

// File: rtl/majline_engine.sv
module majline_engine
   import majline_pkg::*;
#(
   parameter int XW       = 9,
   parameter int YW       = 10,
   parameter int LEN_W    = 10,
   parameter int COL_W    = 8,
   parameter int NARROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_go,
   input  logic [XW-1:0]    org_x,
   input  logic [YW-1:0]    org_y,
   input  logic [LEN_W-1:0] len_long,
   input  logic [LEN_W-1:0] len_short,
   input  logic [COL_W-1:0] colour,
   input  logic             colour_wide,
   input  logic             major_y,
   input  logic             x_rev,
   input  logic             y_rev,
   output logic             pix_valid,
   input  logic             pix_ready,
   output logic [XW-1:0]    pix_x,
   output logic [YW-1:0]    pix_y,
   output logic [COL_W-1:0] pix_col,
   output logic             busy,
   output logic             done
);
   generate
      if (LEN_W < 2 || XW < 1 || YW < 1) begin : g_bad_width
         $error("majline_engine: LEN_W must be >= 2 and coordinate widths >= 1");
      end
      if (NARROW_W < 1 || NARROW_W > COL_W) begin : g_bad_colour
         $error("majline_engine: NARROW_W must lie in 1..COL_W");
      end
   endgenerate

   logic             launch, accept, advance, last, minor_step;
   logic             maj_q, xrev_q, yrev_q;
   logic             step_x, step_y;
   logic [COL_W-1:0] col_sel, col_q;

   assign launch  = cmd_go & ~busy;
   assign accept  = pix_valid & pix_ready;
   assign advance = accept & ~last;

   generate
      if (NARROW_W < COL_W) begin : g_mask
         assign col_sel = colour_wide ? colour
                        : {{(COL_W-NARROW_W){1'b0}}, colour[NARROW_W-1:0]};
      end else begin : g_pass
         assign col_sel = colour;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         maj_q  <= 1'b0;
         xrev_q <= 1'b0;
         yrev_q <= 1'b0;
         col_q  <= '0;
      end else if (launch) begin
         maj_q  <= major_y;
         xrev_q <= x_rev;
         yrev_q <= y_rev;
         col_q  <= col_sel;
      end
   end

   majline_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .launch(launch), .accept(accept),
      .len_long(len_long), .busy(busy), .done(done), .last(last)
   );

   majline_err #(.LEN_W(LEN_W)) u_err (
      .clk(clk), .rst_n(rst_n), .launch(launch), .advance(advance),
      .len_long(len_long), .len_short(len_short), .minor_step(minor_step)
   );

   assign step_x = advance & (maj_q ? minor_step : 1'b1);
   assign step_y = advance & (maj_q ? 1'b1 : minor_step);

   majline_coord #(.W(XW)) u_cx (
      .clk(clk), .rst_n(rst_n), .launch(launch), .init(org_x),
      .step(step_x), .neg(xrev_q), .pos(pix_x)
   );

   majline_coord #(.W(YW)) u_cy (
      .clk(clk), .rst_n(rst_n), .launch(launch), .init(org_y),
      .step(step_y), .neg(yrev_q), .pos(pix_y)
   );

   assign pix_valid = busy;
   assign pix_col   = col_q;
endmodule

// File: rtl/majline_chk.sv
module majline_chk #(
   parameter int XW    = 9,
   parameter int YW    = 10,
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_go,
   input logic             busy,
   input logic             done,
   input logic             pix_valid,
   input logic             pix_ready,
   input logic [XW-1:0]    pix_x,
   input logic [YW-1:0]    pix_y,
   input logic [COL_W-1:0] pix_col,
   input logic             maj
);
   // R9
   done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(pix_valid && pix_ready));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |=>
         (pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_col)));

   // R10
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_go && !(pix_valid && pix_ready)) |=>
         (busy && $stable(pix_x) && $stable(pix_y)));

   // R4
   major_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready && !maj) |=>
         (!pix_valid || pix_x == XW'($past(pix_x) + 1'b1)
                     || pix_x == XW'($past(pix_x) - 1'b1)));

   // R4
   major_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready && maj) |=>
         (!pix_valid || pix_y == YW'($past(pix_y) + 1'b1)
                     || pix_y == YW'($past(pix_y) - 1'b1)));

   // R5
   minor_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready && maj) |=>
         (!pix_valid || pix_x == $past(pix_x)
                     || pix_x == XW'($past(pix_x) + 1'b1)
                     || pix_x == XW'($past(pix_x) - 1'b1)));
endmodule

bind majline_engine majline_chk #(.XW(XW), .YW(YW), .COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .busy(busy), .done(done),
   .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x),
   .pix_y(pix_y), .pix_col(pix_col), .maj(maj_q)
);

// File: tb/sim_majline_engine.sv
module sim_majline_engine;
   localparam int XW = 9, YW = 10, LEN_W = 10, COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_go = 1'b0;
   logic [XW-1:0]    org_x = '0;
   logic [YW-1:0]    org_y = '0;
   logic [LEN_W-1:0] len_long = '0, len_short = '0;
   logic [COL_W-1:0] colour = '0;
   logic             colour_wide = 1'b0, major_y = 1'b0, x_rev = 1'b0, y_rev = 1'b0;
   logic             pix_ready = 1'b0;
   logic             pix_valid, busy, done;
   logic [XW-1:0]    pix_x;
   logic [YW-1:0]    pix_y;
   logic [COL_W-1:0] pix_col;

   int checks = 0;
   int fails = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   majline_engine u0 (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .org_x(org_x), .org_y(org_y),
      .len_long(len_long), .len_short(len_short), .colour(colour),
      .colour_wide(colour_wide), .major_y(major_y), .x_rev(x_rev), .y_rev(y_rev),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
      .pix_col(pix_col), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int minor_off(input int L, input int S, input int k);
      if (L == 0) return 0;
      return ((L / 2) + k * S) / L;
   endfunction

   task automatic run_line(input int L, input int S, input int d, input int sx,
                           input int sy, input int col, input bit wide, input bit inject);
      int k = 0;
      int guard = 0;
      bit fired = 1'b0;
      int dx, dy, ex, ey, ec;
      bit maj = d[0];
      bit xn  = d[1];
      bit yn  = d[2];
      @(negedge clk);
      org_x = XW'(sx); org_y = YW'(sy);
      len_long = LEN_W'(L); len_short = LEN_W'(S);
      colour = COL_W'(col); colour_wide = wide;
      major_y = maj; x_rev = xn; y_rev = yn;
      pix_ready = 1'b0;
      cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      // R2: launch raises busy on the next cycle
      chk(busy === 1'b1, "R2 busy after launch", int'(busy), 1);
      ec = wide ? (col & 255) : (col & 15);
      while (k <= L) begin
         if (cmd_go) begin
            cmd_go = 1'b0;
         end
         if (!pix_valid) begin
            chk(1'b0, "R3 request ended early", k, L + 1);
            break;
         end
         dx = maj ? minor_off(L, S, k) : k;
         dy = maj ? k : minor_off(L, S, k);
         ex = (xn ? (sx - dx) : (sx + dx)) & ((1 << XW) - 1);
         ey = (yn ? (sy - dy) : (sy + dy)) & ((1 << YW) - 1);
         // R4 R5 R6 (R2 for k==0, R8 when repeated after a stall)
         chk(int'(pix_x) == ex, "R4/R5/R6 pixel X", int'(pix_x), ex);
         chk(int'(pix_y) == ey, "R4/R5/R6 pixel Y", int'(pix_y), ey);
         // R7
         chk(int'(pix_col) == ec, "R7 colour", int'(pix_col), ec);
         if (inject && k == 2 && !fired) begin
            // R10: a new command while busy must be ignored
            fired = 1'b1;
            cmd_go = 1'b1;
            org_x = ~org_x; org_y = ~org_y;
            len_long = '0; major_y = ~major_y; x_rev = ~x_rev;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pix_ready = lfsr[0] | lfsr[3];
         if (pix_ready) k++;
         @(negedge clk);
         guard++;
         if (guard > 20000) begin
            chk(1'b0, "R3 line never finished", k, L + 1);
            break;
         end
      end
      cmd_go = 1'b0;
      pix_ready = 1'b0;
      // R9 R3: done pulse right after the final acceptance, no extra pixel
      chk(done === 1'b1, "R9 done after last pixel", int'(done), 1);
      chk(busy === 1'b0, "R3 busy low after L+1 pixels", int'(busy), 0);
      @(negedge clk);
      chk(done === 1'b0, "R9 done lasts one cycle", int'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1
      chk(busy === 1'b0 && pix_valid === 1'b0 && done === 1'b0, "R1 in reset",
          int'({busy, pix_valid, done}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy === 1'b0 && pix_valid === 1'b0 && done === 1'b0, "R1 after reset",
          int'({busy, pix_valid, done}), 0);

      for (int L = 0; L <= 12; L++) begin
         for (int S = 0; S <= L; S++) begin
            for (int d = 0; d < 8; d++) begin
               run_line(L, S, d, (L * 41 + S * 13 + d * 67) % 512,
                        (L * 29 + S * 97 + d * 131) % 1024,
                        (L * 53 + S * 7 + d) & 255, d[0] ^ L[0], 1'b0);
            end
         end
      end
      // R6: wrap at coordinate edges
      run_line(5, 2, 0, 509, 1022, 8'hA5, 1'b1, 1'b0);
      run_line(5, 3, 6, 1, 1, 8'h5A, 1'b0, 1'b0);
      run_line(7, 7, 1, 0, 1020, 8'hFF, 1'b1, 1'b0);
      // R10: command during a busy line
      run_line(9, 4, 0, 100, 200, 8'h3C, 1'b1, 1'b1);
      run_line(6, 1, 5, 300, 50, 8'hC3, 1'b0, 1'b1);
      // R5: diagonal, flat and maximum-length lines
      run_line(700, 700, 1, 20, 30, 8'h11, 1'b1, 1'b0);
      run_line(300, 0, 2, 400, 600, 8'h22, 1'b1, 1'b0);
      run_line(1023, 1000, 0, 500, 3, 8'h99, 1'b0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule